// File: doc/BRIEF.md
# PTP Time Core

This block keeps a 64-bit nanosecond time-of-day for precision time synchronization. On every cycle of its reference clock, while enabled, it advances a counter by a 32.32 fixed-point period: an integer nanosecond step plus the carry out of a 32-bit fractional accumulator. Software trims the frequency by changing the period. It shifts phase through a separate 64-bit offset register. The offset is added to the counter to form the reported current time, and the counter itself is never touched by a phase shift.

Two alarm comparators watch the current time and raise event flags. The event flags clear when software writes one to them, a mask selects which flags drive the interrupt pin, and every register sits behind a simple 32-bit register port. Multi-word values use split-word rules. A low-word read freezes the high word for a later high read. A low-word write is held back until the high-word write commits the whole 64-bit value. The register port carries no stream data, so it has no back-pressure: a read strobe is always answered one cycle later and a write strobe always completes in its own cycle.

Top module: `ptp_time_core`

## Requirements
- R1: After reset every register reads zero except the two alarm values, which read all ones, and the interrupt output is low.
- R2: While the enable bit (control bit 2, control at 0x80) is clear, the counter holds its value, writes to any register other than control are dropped, and reads of those registers return zero.
- R3: On each enabled cycle the counter grows by the active integer period plus the carry of a 32-bit accumulator that adds the active fraction, and the fraction is written at 0xA0.
- R4: The integer period written in control bits 25:16 stays inactive until the next write to 0xA0, and at that write the integer part and the fraction become active together.
- R5: Reading the counter low word at 0x98 captures the counter's high half, and a later read of 0x9C returns that captured value.
- R6: A write to 0x98 is held aside, and a write to 0x9C loads the counter with the high word and the held low word in one step.
- R7: The current time at 0xF0/0xF4 equals counter plus offset modulo 2^64, with the same low-read capture. The offset is written low word first at 0xB0 and committed by its high word at 0xB4, and a two's-complement offset moves time backwards.
- R8: Alarm k has its low word at 0xB8+8k and its high word at 0xBC+8k, and its value commits on the high write, which also re-arms it. An alarm of all ones is disabled. An armed alarm fires exactly once, on the first enabled cycle at which the current time is at least the alarm value, and it sets event bit 16+k.
- R9: The event register at 0x84 clears each bit written as one, a new event wins over a clear in the same cycle, the mask at 0x88 uses bits 16 and 17, and the interrupt output is high exactly when a masked event bit is set.
- R10: Read data appears on rd_data with rd_valid high one cycle after a read strobe, and rd_valid is low otherwise. Control reads back only bits 1:0, 2, 15, 25:16 and 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one time step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | 32 | Read data |
| irq | output | 1 | OR of masked event bits |

## Verification
The assertions assume one access per cycle, with no read and write to the same register in a single cycle. They also assume that the counter does not wrap through 2^64 in the cycle after a step, which is what lets the step-size bound hold. The stimulus issues one strobe per cycle, keeps the counter far from wrap-around, and places the negative offset on the offset register only. The reference model follows the period, alarm and event rules cycle by cycle, so every read and the interrupt pin are compared on each clock.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] A_CTRL   = 8'h80;
  localparam logic [REG_AW-1:0] A_EVT    = 8'h84;
  localparam logic [REG_AW-1:0] A_MASK   = 8'h88;
  localparam logic [REG_AW-1:0] A_CNT_L  = 8'h98;
  localparam logic [REG_AW-1:0] A_CNT_H  = 8'h9C;
  localparam logic [REG_AW-1:0] A_ADDEND = 8'hA0;
  localparam logic [REG_AW-1:0] A_OFF_L  = 8'hB0;
  localparam logic [REG_AW-1:0] A_OFF_H  = 8'hB4;
  localparam logic [REG_AW-1:0] A_ALM_L0 = 8'hB8;
  localparam logic [REG_AW-1:0] A_CUR_L  = 8'hF0;
  localparam logic [REG_AW-1:0] A_CUR_H  = 8'hF4;

  localparam int ALM_STRIDE  = 8;
  localparam int CTRL_EN_BIT = 2;
  localparam int PER_LSB     = 16;
  localparam int EVT_LSB     = 16;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h13FF_8007;
endpackage

// File: rtl/ptp_step_gen.sv
module ptp_step_gen #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [INT_W-1:0]  int_new,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_new,
  output logic [INT_W:0]    step,
  output logic [FRAC_W-1:0] frac_act
);
  logic [INT_W-1:0]  int_act;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, frac_act};
  assign step = {1'b0, int_act} + {{INT_W{1'b0}}, sum[FRAC_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_act  <= '0;
      frac_act <= '0;
      acc_q    <= '0;
    end else begin
      if (frac_wr) begin
        int_act  <= int_new;
        frac_act <= frac_new;
      end
      if (tick) acc_q <= sum[FRAC_W-1:0];
    end
  end

  p_period_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_wr |=> $stable(int_act));
  p_acc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
endmodule

// File: rtl/ptp_alarm_unit.sv
module ptp_alarm_unit #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] now,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [TIME_W/2-1:0] wdata,
  output logic [TIME_W-1:0] alarm,
  output logic              fire
);
  localparam int HALF = TIME_W / 2;
  logic [HALF-1:0] lo_pend;
  logic            done_q;
  logic            armed;

  assign armed = (alarm != {TIME_W{1'b1}});
  assign fire  = tick && armed && !done_q && (now >= alarm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_pend <= '0;
      alarm   <= {TIME_W{1'b1}};
      done_q  <= 1'b0;
    end else begin
      if (lo_wr) lo_pend <= wdata;
      if (hi_wr) begin
        alarm  <= {wdata, lo_pend};
        done_q <= 1'b0;
      end else if (fire) begin
        done_q <= 1'b1;
      end
    end
  end

  p_fire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hi_wr) |=> !fire);
  p_no_fire_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !fire);
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_pkg::*;
#(
  parameter int N_ALARM = 2,
  parameter int INT_W   = 10,
  parameter int FRAC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  localparam int TIME_W = 2 * WORD_W;
  localparam int STEP_W = INT_W + 1;

  logic [WORD_W-1:0] ctrl_q;
  logic              en;
  logic              wr_ok, rd_ok;
  logic [TIME_W-1:0] cnt_q, off_q, cur;
  logic [WORD_W-1:0] cnt_lo_pend, off_lo_pend, cnt_snap, cur_snap;
  logic [STEP_W-1:0] step;
  logic [FRAC_W-1:0] frac_act;
  logic [N_ALARM-1:0] evt_q, mask_q, fire_v, clr_v;
  logic [TIME_W-1:0] alm_val [N_ALARM];
  logic [WORD_W-1:0] rd_mux;
  logic              wr_cnt_l, wr_cnt_h, wr_off_l, wr_off_h, wr_add, wr_evt, wr_mask;

  assign en    = ctrl_q[CTRL_EN_BIT];
  assign wr_ok = reg_wr && en;
  assign rd_ok = reg_rd && en;
  assign cur   = cnt_q + off_q;

  assign wr_cnt_l = wr_ok && (reg_addr == A_CNT_L);
  assign wr_cnt_h = wr_ok && (reg_addr == A_CNT_H);
  assign wr_off_l = wr_ok && (reg_addr == A_OFF_L);
  assign wr_off_h = wr_ok && (reg_addr == A_OFF_H);
  assign wr_add   = wr_ok && (reg_addr == A_ADDEND);
  assign wr_evt   = wr_ok && (reg_addr == A_EVT);
  assign wr_mask  = wr_ok && (reg_addr == A_MASK);

  ptp_step_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (en),
    .int_new  (ctrl_q[PER_LSB +: INT_W]),
    .frac_wr  (wr_add),
    .frac_new (reg_wdata[FRAC_W-1:0]),
    .step     (step),
    .frac_act (frac_act)
  );

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alm
    localparam logic [REG_AW-1:0] LO = A_ALM_L0 + REG_AW'(ALM_STRIDE * i);
    localparam logic [REG_AW-1:0] HI = LO + REG_AW'(4);
    ptp_alarm_unit #(.TIME_W(TIME_W)) u_alm (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (en),
      .now   (cur),
      .lo_wr (wr_ok && (reg_addr == LO)),
      .hi_wr (wr_ok && (reg_addr == HI)),
      .wdata (reg_wdata),
      .alarm (alm_val[i]),
      .fire  (fire_v[i])
    );
  end

  // Control register: always reachable, stores only defined fields.
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_KEEP;
  end

  // Counter and offset with split-word commit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      off_q       <= '0;
      cnt_lo_pend <= '0;
      off_lo_pend <= '0;
    end else begin
      if (wr_cnt_l) cnt_lo_pend <= reg_wdata;
      if (wr_off_l) off_lo_pend <= reg_wdata;
      if (wr_cnt_h)  cnt_q <= {reg_wdata, cnt_lo_pend};
      else if (en)   cnt_q <= cnt_q + TIME_W'(step);
      if (wr_off_h) off_q <= {reg_wdata, off_lo_pend};
    end
  end

  // Events and mask.
  assign clr_v = wr_evt ? reg_wdata[EVT_LSB +: N_ALARM] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_v) | fire_v;
      if (wr_mask) mask_q <= reg_wdata[EVT_LSB +: N_ALARM];
    end
  end

  assign irq = |(evt_q & mask_q);

  // Read path.
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL) begin
      rd_mux = ctrl_q;
    end else if (en) begin
      case (reg_addr)
        A_EVT:    rd_mux = WORD_W'(evt_q) << EVT_LSB;
        A_MASK:   rd_mux = WORD_W'(mask_q) << EVT_LSB;
        A_CNT_L:  rd_mux = cnt_q[WORD_W-1:0];
        A_CNT_H:  rd_mux = cnt_snap;
        A_ADDEND: rd_mux = WORD_W'(frac_act);
        A_OFF_L:  rd_mux = off_q[WORD_W-1:0];
        A_OFF_H:  rd_mux = off_q[TIME_W-1:WORD_W];
        A_CUR_L:  rd_mux = cur[WORD_W-1:0];
        A_CUR_H:  rd_mux = cur_snap;
        default:  rd_mux = '0;
      endcase
      for (int i = 0; i < N_ALARM; i++) begin
        if (reg_addr == A_ALM_L0 + REG_AW'(ALM_STRIDE * i))
          rd_mux = alm_val[i][WORD_W-1:0];
        if (reg_addr == A_ALM_L0 + REG_AW'(ALM_STRIDE * i + 4))
          rd_mux = alm_val[i][TIME_W-1:WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cnt_snap <= '0;
      cur_snap <= '0;
    end else begin
      rd_valid <= reg_rd;
      rd_data  <= reg_rd ? rd_mux : '0;
      if (rd_ok && reg_addr == A_CNT_L) cnt_snap <= cnt_q[TIME_W-1:WORD_W];
      if (rd_ok && reg_addr == A_CUR_L) cur_snap <= cur[TIME_W-1:WORD_W];
    end
  end

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_cnt_h) |=> ((cnt_q - $past(cnt_q)) <= TIME_W'(1 << INT_W)));
  p_offset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_off_h |=> $stable(off_q));
  p_evt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && reg_wdata[EVT_LSB] && !fire_v[0]) |=> !evt_q[0]);
  p_rd_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid);
endmodule

// File: tb/sim_ptp_time_core.sv
module sim_ptp_time_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_valid, irq;
  logic [31:0] rd_data;

  ptp_time_core u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  int    nchk = 0, nerr = 0, cyc = 0;
  string cur_req = "R1";

  // Behavioural reference state
  longint unsigned m_cnt, m_off, m_alm [2];
  bit [31:0] m_ctrl, m_frac, m_acc, m_cnt_lo, m_off_lo, m_cnt_snap, m_cur_snap;
  bit [31:0] m_alm_lo [2];
  bit [9:0]  m_int;
  bit [1:0]  m_evt, m_mask, m_fired;
  bit        exp_valid;
  bit [31:0] exp_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_off = 0; m_ctrl = 0; m_frac = 0; m_acc = 0; m_int = 0;
      m_cnt_lo = 0; m_off_lo = 0; m_cnt_snap = 0; m_cur_snap = 0;
      m_evt = 0; m_mask = 0; m_fired = 0; exp_valid = 0; exp_data = 0;
      for (int i = 0; i < 2; i++) begin m_alm[i] = '1; m_alm_lo[i] = 0; end
    end else begin
      bit en;
      longint unsigned now, sum, step;
      bit [1:0] fire, clr;
      en  = m_ctrl[2];
      now = m_cnt + m_off;
      exp_valid = reg_rd;
      exp_data  = 0;
      if (reg_rd) begin
        if (reg_addr == 8'h80) exp_data = m_ctrl;
        else if (en) begin
          case (reg_addr)
            8'h84: exp_data = {14'd0, m_evt, 16'd0};
            8'h88: exp_data = {14'd0, m_mask, 16'd0};
            8'h98: begin exp_data = m_cnt[31:0]; m_cnt_snap = m_cnt[63:32]; end
            8'h9C: exp_data = m_cnt_snap;
            8'hA0: exp_data = m_frac;
            8'hB0: exp_data = m_off[31:0];
            8'hB4: exp_data = m_off[63:32];
            8'hB8: exp_data = m_alm[0][31:0];
            8'hBC: exp_data = m_alm[0][63:32];
            8'hC0: exp_data = m_alm[1][31:0];
            8'hC4: exp_data = m_alm[1][63:32];
            8'hF0: begin exp_data = now[31:0]; m_cur_snap = now[63:32]; end
            8'hF4: exp_data = m_cur_snap;
            default: exp_data = 0;
          endcase
        end
      end
      for (int i = 0; i < 2; i++)
        fire[i] = en && (m_alm[i] != 64'hFFFF_FFFF_FFFF_FFFF) && !m_fired[i] && (now >= m_alm[i]);
      sum  = longint'(m_acc) + longint'(m_frac);
      step = longint'(m_int) + (sum >> 32);
      clr  = 0;
      if (reg_wr && en && reg_addr == 8'h84) clr = reg_wdata[17:16];
      m_evt = (m_evt & ~clr) | fire;
      for (int i = 0; i < 2; i++) begin
        if (reg_wr && en && reg_addr == 8'hB8 + 8'(8*i)) m_alm_lo[i] = reg_wdata;
        if (reg_wr && en && reg_addr == 8'hBC + 8'(8*i)) begin
          m_alm[i] = {reg_wdata, m_alm_lo[i]}; m_fired[i] = 0;
        end else if (fire[i]) m_fired[i] = 1;
      end
      if (reg_wr && en && reg_addr == 8'h9C) m_cnt = {reg_wdata, m_cnt_lo};
      else if (en) m_cnt = m_cnt + step;
      if (en) m_acc = sum[31:0];
      if (reg_wr && en) begin
        case (reg_addr)
          8'h88: m_mask = reg_wdata[17:16];
          8'h98: m_cnt_lo = reg_wdata;
          8'hA0: begin m_frac = reg_wdata; m_int = m_ctrl[25:16]; end
          8'hB0: m_off_lo = reg_wdata;
          8'hB4: m_off = {reg_wdata, m_off_lo};
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 8'h80) m_ctrl = reg_wdata & 32'h13FF_8007;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_valid === exp_valid, "R10", "rd_valid", 64'(rd_valid), 64'(exp_valid));
      if (exp_valid) chk(rd_data === exp_data, cur_req, "rd_data", 64'(rd_data), 64'(exp_data));
      chk(irq === |(m_evt & m_mask), "R9", "irq", 64'(irq), 64'(|(m_evt & m_mask)));
    end
  end

  task automatic op_wr(input [7:0] a, input [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic op_rd(input [7:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    longint unsigned t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    chk(irq === 1'b0, "R1", "irq after reset", 64'(irq), 0);
    op_rd(8'h80);
    // R2: disabled block ignores writes, returns zeros
    cur_req = "R2";
    op_wr(8'h98, 32'h1234);
    op_wr(8'h9C, 32'h7);
    op_rd(8'h98);
    op_rd(8'hB8);
    // enable, period staged as 3, fraction not yet written
    cur_req = "R4";
    op_wr(8'h80, 32'h1003_8004);
    idle(5);
    op_rd(8'h98);
    cur_req = "R1";
    op_rd(8'hB8); op_rd(8'hBC); op_rd(8'hC0); op_rd(8'hC4);
    op_rd(8'h84); op_rd(8'h88); op_rd(8'hB0); op_rd(8'hA0);
    // R3: nominal step with fraction 1/3
    cur_req = "R3";
    op_wr(8'hA0, 32'h5555_5555);
    idle(7);
    op_rd(8'h98); op_rd(8'h9C); op_rd(8'hA0);
    // R4: new integer period waits for fraction write
    cur_req = "R4";
    op_wr(8'h80, 32'h0007_0004);
    idle(4);
    op_rd(8'h98);
    op_wr(8'hA0, 32'h8000_0000);
    idle(6);
    op_rd(8'h98);
    // R6: split counter write
    cur_req = "R6";
    op_wr(8'h98, 32'hFFFF_FFF0);
    idle(3);
    op_rd(8'h98);
    op_wr(8'h9C, 32'h0000_0001);
    op_rd(8'h98); op_rd(8'h9C);
    // R5: low read freezes high half across a carry
    cur_req = "R5";
    op_wr(8'h98, 32'hFFFF_FFF8);
    op_wr(8'h9C, 32'h0000_0002);
    op_rd(8'h98);
    idle(4);
    op_rd(8'h9C);
    op_rd(8'h98); op_rd(8'h9C);
    // R7: current time with positive then negative offset
    cur_req = "R7";
    op_wr(8'hB0, 32'h0000_0100);
    op_rd(8'hF0);
    op_wr(8'hB4, 32'h0000_0003);
    op_rd(8'hF0); op_rd(8'hF4); op_rd(8'hB4);
    op_wr(8'hB0, 32'hFFFF_F000);
    op_wr(8'hB4, 32'hFFFF_FFFF);
    op_rd(8'hF0); idle(2); op_rd(8'hF4);
    // R8: alarm 0 fires once, raises irq
    cur_req = "R8";
    op_wr(8'h88, 32'h0003_0000);
    t = m_cnt + m_off + 64'd400;
    op_wr(8'hB8, t[31:0]);
    op_wr(8'hBC, t[63:32]);
    op_rd(8'hB8); op_rd(8'hBC);
    chk(irq === 1'b0, "R8", "irq before alarm time", 64'(irq), 0);
    idle(100);
    chk(irq === 1'b1, "R8", "irq after alarm time", 64'(irq), 1);
    op_rd(8'h84);
    // R9: write-one-to-clear, no refire
    cur_req = "R9";
    op_wr(8'h84, 32'h0001_0000);
    chk(irq === 1'b0, "R9", "irq after clear", 64'(irq), 0);
    idle(40);
    chk(irq === 1'b0, "R8", "alarm fired only once", 64'(irq), 0);
    op_rd(8'h84);
    // R9: masked alarm 1 sets event without irq
    op_wr(8'h88, 32'h0001_0000);
    t = m_cnt + m_off + 64'd100;
    op_wr(8'hC0, t[31:0]);
    op_wr(8'hC4, t[63:32]);
    idle(40);
    chk(irq === 1'b0, "R9", "masked event keeps irq low", 64'(irq), 0);
    op_rd(8'h84); op_rd(8'h88);
    op_wr(8'h88, 32'h0002_0000);
    chk(irq === 1'b1, "R9", "unmasking raises irq", 64'(irq), 1);
    op_wr(8'h84, 32'h0003_0000);
    op_rd(8'h84);
    // R10: control readback mask
    cur_req = "R10";
    op_wr(8'h80, 32'hFFFF_FFFF);
    op_rd(8'h80);
    // R2: freeze while disabled, writes dropped
    cur_req = "R2";
    op_wr(8'h80, 32'h0000_0000);
    op_wr(8'h9C, 32'h0000_0055);
    op_wr(8'hB4, 32'h0000_0000);
    op_rd(8'h98); op_rd(8'hF0);
    idle(20);
    op_wr(8'h80, 32'h0003_0004);
    op_rd(8'h98); op_rd(8'h9C); op_rd(8'hB4);
    idle(3);
    summary();
    $finish;
  end
endmodule